// File: doc/BRIEF.md
# Page-mode flash reader

This block sits between a host that wants 16-bit words and an asynchronous parallel NOR flash that can read in pages. The host offers a word address with a valid/ready handshake. The controller drives the flash address bus, lowers chip enable and output enable, and counts a parameterised number of wait cycles. It then samples the flash data bus and returns the word with a one-cycle valid strobe.

The flash groups words into pages of eight. The low three address bits pick the word, and every higher bit picks the page. After a full random access the controller remembers which page is open. While chip enable stays low, a later request whose upper bits match that page is served with the much shorter page wait. Any other request pays the full wait. Once the bus has been idle for a set number of cycles, the controller releases chip enable and output enable and forgets the open page. The next access after that is random again.

Top module: `flash_page_reader`

## Requirements
- R1: A page is eight words. The page tag is `req_addr_i[ADDR_W-1:3]` and bits 2..0 select the word. A change in any tag bit, including the most significant one, makes the request a page miss.
- R2: A page miss waits `MISS_WAIT = max(T_ACC, T_OE, 1)` cycles. The response strobe is high `MISS_WAIT+1` cycles after the cycle in which the request was accepted. A request is accepted in a cycle where `req_valid_i` and `req_ready_o` are both high.
- R3: A request is a page hit when chip enable has stayed low since the previous accepted request and its tag equals that request's tag. A hit waits `max(T_PAGE,1)` cycles, so its strobe is high `max(T_PAGE,1)+1` cycles after acceptance.
- R4: `flash_addr_o` carries the accepted word address from the cycle after acceptance and holds it, unchanged, until the response strobe.
- R5: `flash_ce_no` and `flash_oe_no` are low (asserted) while a read is in progress. After `IDLE_MAX` consecutive idle cycles without a request, both go high together, exactly `IDLE_MAX` cycles after the response strobe. The next request is then a miss even within the same page.
- R6: `req_ready_o` is low from the cycle after acceptance until the response. `rsp_valid_o` is a single-cycle pulse, and `req_ready_o` is high in that same cycle, so back-to-back requests are possible.
- R7: `rsp_data_o` equals the word the flash returns for the accepted address.
- R8: Reset (`rst_ni` low) gives `req_ready_o`=1, `rsp_valid_o`=0, `flash_ce_no`=1 and `flash_oe_no`=1, and it clears the open page. The first request after reset is therefore a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W | Word address of the request |
| rsp_valid_o | output | 1 | One-cycle strobe: read data valid |
| rsp_data_o | output | DATA_W | Read data |
| flash_addr_o | output | ADDR_W | Flash word address bus |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_data_i | input | DATA_W | Flash data bus |

## Verification
The bench runs several request patterns against a flash model. That model timestamps address, chip-enable and output-enable edges and rejects any sample taken before the matching access time.

- **Walk within one page:** separates the short page wait from the full wait.
- **Step into the neighbouring page, or flip only the top address bit:** shows that every tag bit takes part in the comparison.
- **Same-page request after an idle gap long enough to close chip enable, or after a reset:** shows that the open page is forgotten.
- **Back-to-back requests, and a sweep through several pages in a row:** check the handshake and the data path under continuous load.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rd_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/frd_page_track.sv
module frd_page_track #(
  parameter int unsigned TAG_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             load_i,
  input  logic             flush_i,
  output logic             hit_o
);

  logic [TAG_W-1:0] tag_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      vld_q <= 1'b0;
    end else if (flush_i) begin
      vld_q <= 1'b0;
    end else if (load_i) begin
      tag_q <= tag_i;
      vld_q <= 1'b1;
    end
  end

  assign hit_o = vld_q && (tag_q == tag_i);

endmodule

// File: rtl/frd_wait_ctr.sv
module frd_wait_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/frd_idle_ctr.sv
module frd_idle_ctr #(
  parameter int unsigned IDLE_MAX = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int unsigned IW = $clog2(IDLE_MAX + 1);

  logic [IW-1:0] cnt_q;
  logic          last;

  assign last     = (cnt_q == IW'(IDLE_MAX - 1));
  assign expire_o = tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || expire_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 23,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned WORD_OFS_W = 3,
  parameter int unsigned T_ACC      = 7,
  parameter int unsigned T_PAGE     = 2,
  parameter int unsigned T_OE       = 3,
  parameter int unsigned IDLE_MAX   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_ce_no,
  output logic              flash_oe_no,
  input  logic [DATA_W-1:0] flash_data_i
);

  localparam int unsigned TAG_W     = ADDR_W - WORD_OFS_W;
  localparam int unsigned MISS_WAIT = max_of(max_of(T_ACC, T_OE), 1);
  localparam int unsigned HIT_WAIT  = max_of(T_PAGE, 1);
  localparam int unsigned CNT_W     = $clog2(MISS_WAIT + 1);

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q, oe_n_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic              accept, page_hit, wait_zero, idle_tick, idle_close, capture;
  logic [CNT_W-1:0]  wait_load;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign capture   = (state_q == ST_WAIT) && wait_zero;
  assign idle_tick = (state_q == ST_IDLE) && !req_valid_i && !ce_n_q;
  assign wait_load = page_hit ? CNT_W'(HIT_WAIT - 1) : CNT_W'(MISS_WAIT - 1);

  // open page; flushed whenever chip enable is released
  frd_page_track #(.TAG_W(TAG_W)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tag_i  (req_addr_i[ADDR_W-1:WORD_OFS_W]),
    .load_i (accept),
    .flush_i(idle_close),
    .hit_o  (page_hit)
  );

  frd_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(wait_load),
    .run_i     (state_q == ST_WAIT),
    .zero_o    (wait_zero)
  );

  frd_idle_ctr #(.IDLE_MAX(IDLE_MAX)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept || (state_q == ST_WAIT)),
    .tick_i  (idle_tick),
    .expire_o(idle_close)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      ce_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= capture;
      if (capture) rsp_data_q <= flash_data_i;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_WAIT;
            addr_q  <= req_addr_i;
            ce_n_q  <= 1'b0;
            oe_n_q  <= 1'b0;
          end else if (idle_close) begin
            ce_n_q  <= 1'b1;
            oe_n_q  <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (wait_zero) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign flash_addr_o = addr_q;
  assign flash_ce_no  = ce_n_q;
  assign flash_oe_no  = oe_n_q;

endmodule

// File: rtl/frd_checks.sv
module frd_checks
  import flash_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 23,
  parameter int unsigned WORD_OFS_W = 3,
  parameter int unsigned T_ACC      = 7,
  parameter int unsigned T_PAGE     = 2,
  parameter int unsigned T_OE       = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              flash_ce_no,
  input logic              flash_oe_no,
  input logic [ADDR_W-1:0] flash_addr_o
);

  localparam int unsigned MISS_WAIT = max_of(max_of(T_ACC, T_OE), 1);
  localparam int unsigned HIT_WAIT  = max_of(T_PAGE, 1);
  localparam int unsigned LW        = $clog2(MISS_WAIT + 3) + 1;
  localparam int unsigned TW        = ADDR_W - WORD_OFS_W;

  logic [TW-1:0] tag_q;
  logic          tag_vld_q;
  logic [LW-1:0] lat_q, exp_q;
  logic          acc;

  assign acc = req_valid_i && req_ready_o;

  // independent latency model from port activity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q     <= '0;
      tag_vld_q <= 1'b0;
      lat_q     <= '0;
      exp_q     <= '0;
    end else begin
      if (acc) begin
        exp_q     <= (tag_vld_q && !flash_ce_no && (tag_q == req_addr_i[ADDR_W-1:WORD_OFS_W]))
                     ? LW'(HIT_WAIT + 1) : LW'(MISS_WAIT + 1);
        tag_q     <= req_addr_i[ADDR_W-1:WORD_OFS_W];
        tag_vld_q <= 1'b1;
        lat_q     <= LW'(1);
      end else begin
        if (flash_ce_no) tag_vld_q <= 1'b0;
        if (lat_q != '1) lat_q <= lat_q + 1'b1;
      end
    end
  end

  p_latency_r2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (lat_q == exp_q));

  p_addr_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(flash_addr_o));

  p_busy_enables_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> (!flash_ce_no && !flash_oe_no));

  p_rsp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_rsp_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> !req_ready_o);

endmodule

bind flash_page_reader frd_checks #(
  .ADDR_W(ADDR_W), .WORD_OFS_W(WORD_OFS_W), .T_ACC(T_ACC), .T_PAGE(T_PAGE), .T_OE(T_OE)
) u_frd_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .flash_ce_no (flash_ce_no),
  .flash_oe_no (flash_oe_no),
  .flash_addr_o(flash_addr_o)
);

// File: tb/test_flash_page_reader.sv
`timescale 1ns/1ps
module test_flash_page_reader;

  localparam int AW = 23, DW = 16;
  localparam int T_ACC = 7, T_PAGE = 2, T_OE = 3, IDLE_MAX = 6;
  localparam int MISS_LAT = ((T_ACC > T_OE) ? T_ACC : T_OE) + 1;
  localparam int HIT_LAT  = T_PAGE + 1;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, ce_n, oe_n;
  logic [DW-1:0] rsp_data, fdata;
  logic [AW-1:0] faddr;

  always #5 clk = ~clk;

  flash_page_reader #(.ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_PAGE(T_PAGE),
                      .T_OE(T_OE), .IDLE_MAX(IDLE_MAX)) i_flash_page_reader (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .flash_addr_o(faddr), .flash_ce_no(ce_n), .flash_oe_no(oe_n), .flash_data_i(fdata)
  );

  function automatic logic [DW-1:0] fword(input logic [AW-1:0] a);
    return a[15:0] ^ {a[22:16], 9'h0A5};
  endfunction

  assign fdata = oe_n ? 16'h0000 : fword(faddr);

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int last_rsp_cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- flash model: access-time checker ----------------
  int m_age_a = 0, m_age_ce = 0, m_age_oe = 0;
  logic [AW-1:0] m_prev_a = '0;
  logic m_prev_ce = 1'b1, m_prev_oe = 1'b1;
  logic [AW-4:0] m_tag = '0;
  bit m_open = 1'b0;

  always @(negedge clk) begin
    m_age_a  = (faddr != m_prev_a) ? 0 : m_age_a + 1;
    m_age_ce = ce_n ? 0 : ((m_prev_ce) ? 0 : m_age_ce + 1);
    m_age_oe = oe_n ? 0 : ((m_prev_oe) ? 0 : m_age_oe + 1);
    m_prev_a = faddr; m_prev_ce = ce_n; m_prev_oe = oe_n;
    if (ce_n) m_open = 1'b0;
    if (rsp_valid) begin
      bit full, page;
      full = (m_age_a >= T_ACC) && (m_age_ce >= T_ACC) && (m_age_oe >= T_OE);
      page = m_open && (faddr[AW-1:3] == m_tag) && (m_age_a >= T_PAGE) && (m_age_oe >= T_OE);
      // R2 R3: sample never earlier than the access time that applies
      chk(full || page, "R2/R3 flash timing", m_age_a, full ? T_ACC : T_PAGE);
      if (full) begin m_open = 1'b1; m_tag = faddr[AW-1:3]; end
    end
  end

  // ---------------- scoreboard ----------------
  logic [DW-1:0] q_data[$];
  logic [AW-1:0] q_addr[$];
  int            q_lat[$];
  int            q_cyc[$];
  bit            prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (prev_rsp) chk(!rsp_valid, "R6 single-cycle strobe", rsp_valid, 0);
    prev_rsp = rsp_valid;
    if (rsp_valid) begin
      last_rsp_cyc = cyc;
      if (q_data.size() == 0) begin
        chk(1'b0, "R6 unexpected response", 1, 0);
      end else begin
        logic [DW-1:0] ed; logic [AW-1:0] ea; int el, ec;
        ed = q_data.pop_front(); ea = q_addr.pop_front();
        el = q_lat.pop_front();  ec = q_cyc.pop_front();
        chk(rsp_data == ed, "R7 read data", rsp_data, ed);
        chk(faddr == ea, "R4 flash address held", faddr, ea);
        chk(cyc - ec == el, (el == HIT_LAT) ? "R3 hit latency" : "R2 miss latency", cyc - ec, el);
        chk(req_ready, "R6 ready with response", req_ready, 1);
      end
    end
  end

  // ---------------- driver ----------------
  logic [AW-4:0] b_tag = '0;
  bit            b_vld = 1'b0;

  task automatic do_read(input logic [AW-1:0] a, input int gap);
    bit hit;
    repeat (gap) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    hit = b_vld && (b_tag == a[AW-1:3]) && !ce_n;   // R1 R3 page rule
    q_data.push_back(fword(a));
    q_addr.push_back(a);
    q_lat.push_back(hit ? HIT_LAT : MISS_LAT);
    q_cyc.push_back(cyc);
    b_tag = a[AW-1:3]; b_vld = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 busy after accept", req_ready, 0);
    chk(!ce_n && !oe_n, "R5 enables low while busy", {ce_n, oe_n}, 0);
  endtask

  task automatic drain();
    while (q_data.size() != 0) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R8 reset strobe", rsp_valid, 0);
    chk(ce_n == 1'b1, "R8 reset chip enable", ce_n, 1);
    chk(oe_n == 1'b1, "R8 reset output enable", oe_n, 1);
    rst_ni = 1'b1;
    b_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // miss, then hits walking inside the page
    do_read(23'h000010, 0);
    do_read(23'h000011, 0);   // R3
    do_read(23'h000017, 0);
    do_read(23'h000013, 2);
    // R1: neighbouring page, then hit, then only top bit flipped
    do_read(23'h000018, 0);
    do_read(23'h00001F, 0);
    do_read(23'h40001F, 0);
    do_read(23'h40001A, 1);
    drain();
    // R5: chip enable released after the idle window
    begin
      int t0;
      t0 = last_rsp_cyc;
      while (!ce_n) @(negedge clk);
      chk(cyc - t0 == IDLE_MAX, "R5 idle release time", cyc - t0, IDLE_MAX);
      chk(oe_n == 1'b1, "R5 output enable released", oe_n, 1);
    end
    do_read(23'h40001B, 0);   // R5 same page after release: miss
    drain();
    // R8: reset forgets the open page
    do_read(23'h123450, 0);
    drain();
    do_reset();
    do_read(23'h123451, 0);
    // sweep pages back to back
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 8; w++) begin
        do_read({p[3:0], 16'h2AA, 3'(7 - w)}, 0);
      end
    end
    do_read(23'h7FFFF8, 0);
    do_read(23'h7FFFFF, 0);
    drain();
    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R6 all responses returned", q_data.size(), 0);
    finish_run();
  end

endmodule